// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control logic that sits beside a successive-approximation converter. It accepts two kinds of register write. A control byte holds the two clock-divider selects and the continuous-mode bit. A trigger write goes to the low result address; its data is ignored and it asks for a conversion. From the system clock it derives two enables: a conversion-clock tick and a sample-clock tick. Each uses its own selectable divide ratio.

A conversion first counts a fixed number of sample ticks and then a fixed number of conversion ticks. In place of the analog comparator and DAC, the block latches a test value from an input port on the last conversion tick. A busy flag covers the whole conversion. A sticky end-of-conversion interrupt is raised when the result is written. Continuous operation can be entered in three ways, depending on whether any conversion has completed since reset. Leaving continuous mode always lets the running conversion finish.

Top module: `adc_seq`

## Requirements
- R1: The conversion tick `conv_tick` pulses once every 4, 8, 16 or 32 clocks for `ctrl_wdata[1:0]` = 00, 01, 10, 11. After reset the select is 01, a period of 8.
- R2: The sample tick `samp_tick` pulses once every 2, 8, 16 or 32 clocks for `ctrl_wdata[3:2]` = 00, 01, 10, 11. After reset the select is 00, a period of 2.
- R3: A trigger write while idle sets `busy` on the next clock. When the conversion ends, `result` takes `test_value`, `irq` rises and `busy` falls, all on the same clock edge. The trigger data has no effect.
- R4: A trigger write while `busy` is high is ignored: the running conversion is neither restarted nor extended, and no extra conversion follows it.
- R5: Writing `ctrl_wdata[7]` = 1 during a single conversion turns it continuous. After each end a new conversion starts with no idle cycle.
- R6: Writing `ctrl_wdata[7]` = 1 while idle, once at least one conversion has completed since reset, sets `busy` on the next clock.
- R7: Writing `ctrl_wdata[7]` = 1 before any conversion has completed since reset starts nothing. The next trigger write starts continuous operation.
- R8: Writing `ctrl_wdata[7]` = 0 during continuous operation lets the current conversion end with its result and interrupt, after which `busy` stays low.
- R9: `irq` stays high until a cycle with `irq_clr` high clears it. An end of conversion in the same cycle wins over the clear.
- R10: A conversion lasts `SAMPLE_TICKS` sample ticks followed by `CONV_TICKS` conversion ticks, so its length lies within one tick period of each phase of that sum.
- R11: After reset `busy`, `irq` and `cont_mode` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | [1:0] conversion divider, [3:2] sample divider, [7] continuous mode |
| trig_we | input | 1 | Write strobe to the low result address (starts a conversion) |
| trig_wdata | input | 8 | Data of the trigger write, ignored |
| irq_clr | input | 1 | Clears the interrupt flag |
| test_value | input | RES_W | Value latched as the conversion result |
| conv_tick | output | 1 | Conversion clock enable |
| samp_tick | output | 1 | Sample clock enable |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | End-of-conversion interrupt flag |
| cont_mode | output | 1 | Current continuous-mode bit |
| result | output | RES_W | Last conversion result |

## Verification
The assertions assume that every write strobe and `irq_clr` is a one-cycle pulse with its data valid in that cycle. They also assume that `test_value` is held steady around the final conversion tick. The bench drives all inputs on the falling edge and holds each strobe for exactly one clock. It changes `test_value` only while the block is idle, or long before a conversion ends. Divider selects are changed only while idle, so that every measured tick period and conversion length belongs to a single setting.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int RES_W        = 10,
  parameter int SAMPLE_TICKS = 4,
  parameter int CONV_TICKS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             trig_we,
  input  logic [7:0]       trig_wdata,
  input  logic             irq_clr,
  input  logic [RES_W-1:0] test_value,
  output logic             conv_tick,
  output logic             samp_tick,
  output logic             busy,
  output logic             irq,
  output logic             cont_mode,
  output logic [RES_W-1:0] result
);
  localparam int MAXT   = (SAMPLE_TICKS > CONV_TICKS) ? SAMPLE_TICKS : CONV_TICKS;
  localparam int STEP_W = $clog2(MAXT) + 1;

  logic [4:0]        pre_cnt;
  logic [1:0]        conv_sel, samp_sel;
  logic [4:0]        cmask, smask;
  logic              sampling, done_once;
  logic [STEP_W-1:0] step;
  logic              set_mode, start_req, finish;

  always_comb begin
    case (conv_sel)
      2'd0: cmask = 5'd3;
      2'd1: cmask = 5'd7;
      2'd2: cmask = 5'd15;
      default: cmask = 5'd31;
    endcase
    case (samp_sel)
      2'd0: smask = 5'd1;
      2'd1: smask = 5'd7;
      2'd2: smask = 5'd15;
      default: smask = 5'd31;
    endcase
  end

  assign conv_tick = (pre_cnt & cmask) == cmask;
  assign samp_tick = (pre_cnt & smask) == smask;
  assign set_mode  = ctrl_we & ctrl_wdata[7] & ~cont_mode;
  assign start_req = ~busy & (trig_we | (set_mode & done_once));
  assign finish    = busy & ~sampling & conv_tick & (step == STEP_W'(CONV_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      conv_sel  <= 2'b01;
      samp_sel  <= 2'b00;
      cont_mode <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 5'd1;
      if (ctrl_we) begin
        conv_sel  <= ctrl_wdata[1:0];
        samp_sel  <= ctrl_wdata[3:2];
        cont_mode <= ctrl_wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sampling  <= 1'b0;
      step      <= '0;
      done_once <= 1'b0;
      result    <= '0;
    end else if (start_req) begin
      busy     <= 1'b1;
      sampling <= 1'b1;
      step     <= '0;
    end else if (busy) begin
      if (sampling && samp_tick) begin
        if (step == STEP_W'(SAMPLE_TICKS - 1)) begin
          sampling <= 1'b0;
          step     <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end else if (finish) begin
        result    <= test_value;
        done_once <= 1'b1;
        step      <= '0;
        sampling  <= 1'b1;
        busy      <= cont_mode | set_mode;
      end else if (!sampling && conv_tick) begin
        step <= step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (finish)  irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  logic unused_ok;
  assign unused_ok = ^trig_wdata;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             trig_we,
  input logic             irq_clr,
  input logic [RES_W-1:0] test_value,
  input logic             conv_tick,
  input logic             busy,
  input logic             irq,
  input logic             cont_mode,
  input logic [RES_W-1:0] result
);
  AST_TICK_NOT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick && !ctrl_we |=> !conv_tick); // R1
  AST_BUSY_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig_we |=> busy); // R3
  AST_RESULT_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> result == $past(test_value)); // R3
  AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(irq)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R9
  AST_STOP_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !cont_mode); // R8
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int RES_W = 10;
  localparam int S = 4;
  localparam int C = 10;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, trig_we = 0, irq_clr = 0;
  logic [7:0] ctrl_wdata = 0, trig_wdata = 0;
  logic [RES_W-1:0] test_value = 0;
  logic conv_tick, samp_tick, busy, irq, cont_mode;
  logic [RES_W-1:0] result;
  int n_run = 0, n_fail = 0;

  adc_seq #(.RES_W(RES_W), .SAMPLE_TICKS(S), .CONV_TICKS(C)) u_adc_seq (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input int cd, input int sd, input bit m);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = {m, 3'b0, 2'(sd), 2'(cd)};
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic trigger(input logic [7:0] d);
    @(negedge clk);
    trig_we = 1; trig_wdata = d;
    @(negedge clk);
    trig_we = 0;
  endtask

  task automatic clear_irq();
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic period(input bit which, output int p);
    p = 0;
    while (!(which ? conv_tick : samp_tick)) @(negedge clk);
    @(negedge clk); p = 1;
    while (!(which ? conv_tick : samp_tick) && p < 100) begin @(negedge clk); p++; end
  endtask

  function automatic int crat(int c); return 4 << c; endfunction
  function automatic int srat(int c); return (c == 0) ? 2 : (4 << c); endfunction

  task automatic t_reset();
    int p;
    check(busy == 0 && irq == 0 && cont_mode == 0, "R11 reset flags", {busy, irq, cont_mode}, 0);
    check(result == 0, "R11 reset result", result, 0);
    period(1, p); check(p == 8, "R1 default conv period", p, 8);
    period(0, p); check(p == 2, "R2 default sample period", p, 2);
  endtask

  task automatic t_dividers();
    int p;
    for (int c = 0; c < 4; c++) begin
      wr_ctrl(c, 3 - c, 0);
      period(1, p); check(p == crat(c), "R1 conv period", p, crat(c));
      period(0, p); check(p == srat(3 - c), "R2 sample period", p, srat(3 - c));
    end
    wr_ctrl(0, 0, 0);
  endtask

  task automatic t_mode_before_any();
    int cyc;
    wr_ctrl(0, 0, 1);
    repeat (200) @(negedge clk);
    check(busy == 0 && irq == 0, "R7 mode bit alone starts nothing", busy, 0);
    test_value = 10'h155;
    trigger(8'hFF);
    check(busy == 1, "R7 trigger starts", busy, 1);
    wait_irq(cyc);
    check(result == 10'h155, "R7 result", result, 10'h155);
    check(busy == 1, "R7 continuous restart", busy, 1);
    clear_irq();
    wait_irq(cyc);
    check(irq == 1, "R7 second conversion", irq, 1);
    clear_irq();
    wr_ctrl(0, 0, 0);
    wait_irq(cyc);
    check(irq == 1, "R8 current conversion completes", irq, 1);
    @(negedge clk);
    check(busy == 0, "R8 stops after end", busy, 0);
    clear_irq();
    repeat (150) @(negedge clk);
    check(busy == 0 && irq == 0, "R8 no further conversion", irq, 0);
  endtask

  task automatic t_single();
    int cyc;
    int lo = (S - 1) * 2 + (C - 1) * 4;
    int hi = S * 2 + C * 4 + 2;
    test_value = 10'h2A5;
    @(negedge clk);
    trig_we = 1; trig_wdata = 8'h00;
    @(negedge clk);
    trig_we = 0;
    check(busy == 1, "R3 busy next clock", busy, 1);
    wait_irq(cyc);
    cyc++;
    check(result == 10'h2A5, "R3 result latched", result, 10'h2A5);
    check(busy == 0, "R3 busy falls with irq", busy, 0);
    check(cyc > lo && cyc <= hi, "R10 conversion length", cyc, hi);
    repeat (20) @(negedge clk);
    check(irq == 1, "R9 irq held", irq, 1);
    clear_irq();
    check(irq == 0, "R9 irq cleared", irq, 0);
  endtask

  task automatic t_trig_busy();
    int cyc;
    int hi = S * 2 + C * 4 + 2;
    test_value = 10'h0F0;
    trigger(8'h12);
    repeat (12) @(negedge clk);
    trigger(8'h34);
    test_value = 10'h0F1;
    wait_irq(cyc);
    cyc += 14;
    check(cyc <= hi, "R4 no restart on busy trigger", cyc, hi);
    check(result == 10'h0F1, "R4 result", result, 10'h0F1);
    clear_irq();
    repeat (150) @(negedge clk);
    check(busy == 0 && irq == 0, "R4 no queued conversion", irq, 0);
  endtask

  task automatic t_set_during_single();
    int cyc;
    trigger(8'h00);
    repeat (5) @(negedge clk);
    wr_ctrl(0, 0, 1);
    wait_irq(cyc);
    check(busy == 1, "R5 continues after end", busy, 1);
    clear_irq();
    wait_irq(cyc);
    check(irq == 1, "R5 next conversion ends", irq, 1);
    clear_irq();
    wr_ctrl(0, 0, 0);
    wait_irq(cyc);
    @(negedge clk);
    check(busy == 0, "R8 stop after mode clear", busy, 0);
    clear_irq();
  endtask

  task automatic t_set_idle_after_done();
    int cyc;
    check(busy == 0, "R6 idle before", busy, 0);
    wr_ctrl(0, 0, 1);
    check(busy == 1, "R6 mode bit starts at once", busy, 1);
    wr_ctrl(0, 0, 0);
    wait_irq(cyc);
    @(negedge clk);
    check(busy == 0, "R8 stop", busy, 0);
    clear_irq();
    test_value = 10'h3C3;
    @(negedge clk);
    trig_we = 1;
    @(negedge clk);
    trig_we = 0;
    wait_irq(cyc);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check(irq == 0 && result == 10'h3C3, "R9 clear after end", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dividers();
    t_mode_before_any();
    t_single();
    t_trig_busy();
    t_set_during_single();
    t_set_idle_after_done();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule